// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is the execution half of a small processor. An external sequencer sets a control word, and the block carries out the register transfer that word describes in one clock cycle. The block has a file of four general registers with two combinational read ports. Both read buses feed an arithmetic/logic unit that drives four status flags. A word-addressed scratch RAM sits beside the unit. A bypass lets a literal value from the control word stand in for the second operand. A final selector decides whether the register being written receives the arithmetic result or the word read from RAM.

Port A of the register file supplies the RAM address. Port B supplies the store data. The RAM read is asynchronous, so a transfer such as "r3 gets memory at r0" completes in the same cycle it is issued. So does "memory at r0 gets r3". A sequencer that chains such control words builds load, modify and store sequences from single-cycle steps.

Top module: `cw_datapath`

## Requirements
- R1: An active-high synchronous reset clears all four registers to zero. RAM contents are not cleared.
- R2: The `srca_sel` and `srcb_sel` inputs (2 bits each) pick the registers that appear on `bus_a` and `bus_b`. Both reads are combinational, with no clock edge needed.
- R3: A register loads `wb_data` only on a rising clock edge with `reg_we` = 1, and only the register numbered by `dst_sel`. With `reg_we` = 0 no register changes.
- R4: The arithmetic codes on `alu_fn` are: 00001 A+1, 00010 A+B, 00011 A+B+1, 00100 A+~B, 00101 A-B, 00110 A-1. The codes 00000 and 00111 pass A unchanged.
- R5: The logic and shift codes are: 01000 AND, 01010 OR, 01100 XOR, 01110 ~A, 10000 pass B, 10100 B shifted right by one, 11000 B shifted left by one. Shifts fill with 0. Every other code yields 0.
- R6: `flag_n` is the result MSB and `flag_z` is 1 exactly when the result is zero. For the codes 00001 to 00110, `flag_c` is the carry out and `flag_v` is two's-complement overflow. For all other codes both are 0.
- R7: With `use_const` = 1, `const_in` replaces the ALU B operand. RAM store data and `bus_b` still come from the register on port B.
- R8: The RAM is addressed by `bus_a`. It stores `bus_b` on a rising edge when `mem_we` = 1 and is left unchanged when `mem_we` = 0.
- R9: With `wb_from_mem` = 0 the ALU result is written back; with 1 the RAM word at `bus_a` is written back. A load into a register, including the address register itself, completes in one cycle.
- R10: The RAM holds 2^DW words of DW bits, so every value of `bus_a`, including all-ones, is a distinct location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the registers |
| dst_sel | input | 2 | Register number to be written |
| srca_sel | input | 2 | Register number driven on bus A |
| srcb_sel | input | 2 | Register number driven on bus B |
| reg_we | input | 1 | Register write enable |
| use_const | input | 1 | Replace ALU operand B with `const_in` |
| alu_fn | input | 5 | ALU function code |
| wb_from_mem | input | 1 | Write-back source: 0 ALU result, 1 RAM word |
| mem_we | input | 1 | RAM write enable |
| const_in | input | DW | Literal operand |
| flag_v | output | 1 | Signed overflow |
| flag_c | output | 1 | Carry out |
| flag_n | output | 1 | Result negative |
| flag_z | output | 1 | Result zero |
| bus_a | output | DW | Register read port A tap |
| bus_b | output | DW | Register read port B tap |

## Verification
The assertions check these rules on every cycle:
- reset clearing the registers;
- a write landing exactly in the addressed register;
- every register holding when writes are disabled;
- a RAM store landing at the bus A address;
- carry and overflow staying low outside arithmetic codes;
- undefined codes giving a zero result.

The result values of each function code, the carry and overflow values at signed and unsigned wrap points, and the one-cycle load into the address register need the bench's directed scenarios. So do the store taking register data even with the literal bypass on and the all-ones RAM address being distinct.

// File: rtl/cwdp_pkg.sv
package cwdp_pkg;

    typedef enum logic [4:0] {
        OP_PASS_A  = 5'b00000,
        OP_INC     = 5'b00001,
        OP_ADD     = 5'b00010,
        OP_ADD_C   = 5'b00011,
        OP_ADD_NB  = 5'b00100,
        OP_SUB     = 5'b00101,
        OP_DEC     = 5'b00110,
        OP_PASS_A2 = 5'b00111,
        OP_AND     = 5'b01000,
        OP_OR      = 5'b01010,
        OP_XOR     = 5'b01100,
        OP_NOT_A   = 5'b01110,
        OP_PASS_B  = 5'b10000,
        OP_SHR_B   = 5'b10100,
        OP_SHL_B   = 5'b11000
    } alu_op_e;

    typedef struct packed {
        logic v;
        logic c;
        logic n;
        logic z;
    } flags_t;

    // Codes that carry a real adder operation (carry/overflow meaningful).
    function automatic logic op_is_arith(logic [4:0] code);
        return (code != 5'b00000) && (code[4:3] == 2'b00) && (code != 5'b00111);
    endfunction

    // Codes with a defined function; all others produce zero.
    function automatic logic op_is_known(logic [4:0] code);
        logic known;
        case (code)
            5'b00000, 5'b00001, 5'b00010, 5'b00011,
            5'b00100, 5'b00101, 5'b00110, 5'b00111,
            5'b01000, 5'b01010, 5'b01100, 5'b01110,
            5'b10000, 5'b10100, 5'b11000: known = 1'b1;
            default:                      known = 1'b0;
        endcase
        return known;
    endfunction

endpackage

// File: rtl/cwdp_regfile.sv
module cwdp_regfile #(
    parameter int DW = 8,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [SW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [SW-1:0] raddr_a,
    input  logic [SW-1:0] raddr_b,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b
);
    localparam int NREG = 1 << SW;

    logic [NREG-1:0][DW-1:0] q;
    logic [NREG-1:0]         load;

    // Write decoder, gated by the enable
    for (genvar i = 0; i < NREG; i++) begin : g_dec
        assign load[i] = we && (waddr == SW'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            for (int k = 0; k < NREG; k++) begin
                if (load[k]) q[k] <= wdata;
            end
        end
    end

    assign rdata_a = q[raddr_a];
    assign rdata_b = q[raddr_b];

    // R1
    regs_clear_chk: assert property (@(posedge clk) rst |=> (q == '0));

    // R3
    reg_write_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (q[$past(waddr)] == $past(wdata)));

    // R3
    reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

endmodule

// File: rtl/cwdp_alu.sv
module cwdp_alu
    import cwdp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [4:0]    fn,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] res,
    output flags_t        flags
);
    alu_op_e       op;
    logic [DW-1:0] addend;
    logic          cin;
    logic          arith;
    logic [DW:0]   sum;

    assign op = alu_op_e'(fn);

    // Adder operand selection
    always_comb begin
        addend = '0;
        cin    = 1'b0;
        arith  = 1'b1;
        case (op)
            OP_INC:    cin = 1'b1;
            OP_ADD:    addend = b;
            OP_ADD_C:  begin addend = b;  cin = 1'b1; end
            OP_ADD_NB: addend = ~b;
            OP_SUB:    begin addend = ~b; cin = 1'b1; end
            OP_DEC:    addend = '1;
            default:   arith = 1'b0;
        endcase
    end

    assign sum = {1'b0, a} + {1'b0, addend} + {{DW{1'b0}}, cin};

    // Result selection
    always_comb begin
        case (op)
            OP_PASS_A, OP_PASS_A2: res = a;
            OP_INC, OP_ADD, OP_ADD_C,
            OP_ADD_NB, OP_SUB, OP_DEC: res = sum[DW-1:0];
            OP_AND:    res = a & b;
            OP_OR:     res = a | b;
            OP_XOR:    res = a ^ b;
            OP_NOT_A:  res = ~a;
            OP_PASS_B: res = b;
            OP_SHR_B:  res = {1'b0, b[DW-1:1]};
            OP_SHL_B:  res = {b[DW-2:0], 1'b0};
            default:   res = '0;
        endcase
    end

    always_comb begin
        flags.c = arith && sum[DW];
        flags.v = arith && (a[DW-1] == addend[DW-1]) && (sum[DW-1] != a[DW-1]);
        flags.n = res[DW-1];
        flags.z = (res == '0);
    end

endmodule

// File: rtl/cwdp_ram.sv
module cwdp_ram #(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    // Asynchronous read
    assign rdata = mem[addr];

    // R8
    ram_store_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/cw_datapath.sv
module cw_datapath
    import cwdp_pkg::*;
#(
    parameter int DW = 8,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] dst_sel,
    input  logic [SW-1:0] srca_sel,
    input  logic [SW-1:0] srcb_sel,
    input  logic          reg_we,
    input  logic          use_const,
    input  logic [4:0]    alu_fn,
    input  logic          wb_from_mem,
    input  logic          mem_we,
    input  logic [DW-1:0] const_in,
    output logic          flag_v,
    output logic          flag_c,
    output logic          flag_n,
    output logic          flag_z,
    output logic [DW-1:0] bus_a,
    output logic [DW-1:0] bus_b
);
    logic [DW-1:0] rd_a, rd_b;
    logic [DW-1:0] alu_b;
    logic [DW-1:0] alu_res;
    logic [DW-1:0] mem_rd;
    logic [DW-1:0] wb_data;
    flags_t        flg;

    cwdp_regfile #(.DW(DW), .SW(SW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .waddr   (dst_sel),
        .wdata   (wb_data),
        .raddr_a (srca_sel),
        .raddr_b (srcb_sel),
        .rdata_a (rd_a),
        .rdata_b (rd_b)
    );

    assign alu_b = use_const ? const_in : rd_b;

    cwdp_alu #(.DW(DW)) u_alu (
        .fn    (alu_fn),
        .a     (rd_a),
        .b     (alu_b),
        .res   (alu_res),
        .flags (flg)
    );

    cwdp_ram #(.DW(DW), .AW(DW)) u_ram (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .addr  (rd_a),
        .wdata (rd_b),
        .rdata (mem_rd)
    );

    assign wb_data = wb_from_mem ? mem_rd : alu_res;

    assign bus_a  = rd_a;
    assign bus_b  = rd_b;
    assign flag_v = flg.v;
    assign flag_c = flg.c;
    assign flag_n = flg.n;
    assign flag_z = flg.z;

    // R6
    cv_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !op_is_arith(alu_fn) |-> (!flag_c && !flag_v));

    // R5
    unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !op_is_known(alu_fn) |-> (flag_z && !flag_n));

endmodule

// File: tb/cw_datapath_test.sv
module cw_datapath_test;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] dst_sel, srca_sel, srcb_sel;
    logic       reg_we, use_const, wb_from_mem, mem_we;
    logic [4:0] alu_fn;
    logic [7:0] const_in;
    logic       flag_v, flag_c, flag_n, flag_z;
    logic [7:0] bus_a, bus_b;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    cw_datapath #(.DW(8), .SW(2)) uut (
        .clk(clk), .rst(rst), .dst_sel(dst_sel), .srca_sel(srca_sel),
        .srcb_sel(srcb_sel), .reg_we(reg_we), .use_const(use_const),
        .alu_fn(alu_fn), .wb_from_mem(wb_from_mem), .mem_we(mem_we),
        .const_in(const_in), .flag_v(flag_v), .flag_c(flag_c),
        .flag_n(flag_n), .flag_z(flag_z), .bus_a(bus_a), .bus_b(bus_b)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        reg_we = 0; mem_we = 0; use_const = 0; wb_from_mem = 0;
        alu_fn = 5'b00000; const_in = 8'h00;
        dst_sel = 0; srca_sel = 0; srcb_sel = 0;
    endtask

    // Load a literal into register r through the pass-B path
    task automatic ld(input logic [1:0] r, input logic [7:0] v);
        @(negedge clk);
        alu_fn = 5'b10000; use_const = 1; const_in = v;
        dst_sel = r; reg_we = 1; wb_from_mem = 0; mem_we = 0;
        @(negedge clk);
        reg_we = 0; use_const = 0;
    endtask

    task automatic rd_a(input logic [1:0] r, output logic [7:0] v);
        srca_sel = r; #1; v = bus_a;
    endtask

    task automatic rd_b(input logic [1:0] r, output logic [7:0] v);
        srcb_sel = r; #1; v = bus_b;
    endtask

    // Store register rv to RAM at address held in ra
    task automatic store(input logic [1:0] ra, input logic [1:0] rv);
        @(negedge clk);
        srca_sel = ra; srcb_sel = rv; mem_we = 1; reg_we = 0;
        use_const = 1; const_in = 8'h11;
        @(negedge clk);
        mem_we = 0; use_const = 0;
    endtask

    // Load RAM at address in ra into rd
    task automatic load(input logic [1:0] ra, input logic [1:0] rd);
        @(negedge clk);
        srca_sel = ra; dst_sel = rd; wb_from_mem = 1; reg_we = 1; mem_we = 0;
        @(negedge clk);
        reg_we = 0; wb_from_mem = 0;
    endtask

    task automatic alu_case(input logic [7:0] a, input logic [7:0] b,
                            input logic [4:0] fn, input logic [7:0] exp_res,
                            input logic [3:0] exp_vcnz, input string req);
        logic [7:0] got;
        ld(0, a);
        srca_sel = 0; use_const = 1; const_in = b; alu_fn = fn;
        #1;
        check({req, " flags vcnz"}, {flag_v, flag_c, flag_n, flag_z}, exp_vcnz);
        dst_sel = 1; reg_we = 1; wb_from_mem = 0;
        @(negedge clk);
        reg_we = 0; use_const = 0;
        rd_a(1, got);
        check({req, " result"}, got, exp_res);
    endtask

    task automatic t_initial_reset();
        logic [7:0] v;
        for (int r = 0; r < 4; r++) begin
            rd_a(2'(r), v);
            check("R1 initial reset", v, 0);
        end
    endtask

    task automatic t_regs();
        logic [7:0] v;
        ld(0, 8'h10); ld(1, 8'h7F); ld(2, 8'h01); ld(3, 8'hC3);
        rd_a(0, v); check("R3 write r0", v, 8'h10);
        rd_a(1, v); check("R3 write r1", v, 8'h7F);
        rd_a(2, v); check("R3 write r2", v, 8'h01);
        rd_a(3, v); check("R3 write r3", v, 8'hC3);
        rd_b(3, v); check("R2 bus_b r3", v, 8'hC3);
        rd_b(1, v); check("R2 bus_b r1", v, 8'h7F);
        // No write when reg_we is low
        @(negedge clk);
        alu_fn = 5'b10000; use_const = 1; const_in = 8'hEE; dst_sel = 1; reg_we = 0;
        @(negedge clk);
        use_const = 0;
        rd_a(1, v); check("R3 no write with reg_we=0", v, 8'h7F);
        rd_a(2, v); check("R3 neighbour unchanged", v, 8'h01);
    endtask

    task automatic t_alu();
        // vcnz packing: {v, c, n, z}
        alu_case(8'h7F, 8'h01, 5'b00010, 8'h80, 4'b1010, "R4 R6 add overflow");
        alu_case(8'hFF, 8'h01, 5'b00010, 8'h00, 4'b0101, "R4 R6 add carry");
        alu_case(8'h41, 8'h00, 5'b00001, 8'h42, 4'b0000, "R4 inc");
        alu_case(8'h10, 8'h20, 5'b00011, 8'h31, 4'b0000, "R4 add plus one");
        alu_case(8'h10, 8'h01, 5'b00100, 8'h0E, 4'b0100, "R4 add not b");
        alu_case(8'h05, 8'h07, 5'b00101, 8'hFE, 4'b0010, "R4 R6 sub borrow");
        alu_case(8'h80, 8'h01, 5'b00101, 8'h7F, 4'b1100, "R4 R6 sub overflow");
        alu_case(8'h00, 8'h00, 5'b00110, 8'hFF, 4'b0010, "R4 dec wrap");
        alu_case(8'h9A, 8'hFF, 5'b00000, 8'h9A, 4'b0010, "R4 pass a");
        alu_case(8'h9A, 8'hFF, 5'b00111, 8'h9A, 4'b0010, "R4 pass a alt");
        alu_case(8'hF0, 8'h3C, 5'b01000, 8'h30, 4'b0000, "R5 and");
        alu_case(8'hF0, 8'h0F, 5'b01010, 8'hFF, 4'b0010, "R5 R6 or");
        alu_case(8'hAA, 8'hFF, 5'b01100, 8'h55, 4'b0000, "R5 xor");
        alu_case(8'h0F, 8'h00, 5'b01110, 8'hF0, 4'b0010, "R5 not a");
        alu_case(8'h00, 8'h5A, 5'b10000, 8'h5A, 4'b0000, "R5 R7 pass b");
        alu_case(8'h00, 8'h81, 5'b10100, 8'h40, 4'b0000, "R5 shift right");
        alu_case(8'hFF, 8'h81, 5'b11000, 8'h02, 4'b0000, "R5 shift left");
        alu_case(8'hFF, 8'hFF, 5'b01001, 8'h00, 4'b0001, "R5 unused code");
        alu_case(8'hFF, 8'hFF, 5'b11111, 8'h00, 4'b0001, "R5 unused code top");
    endtask

    task automatic t_mem();
        logic [7:0] v;
        ld(0, 8'h20); ld(1, 8'h77);
        store(0, 1);
        rd_b(1, v); check("R7 bus_b shows register under const", v, 8'h77);
        load(0, 3);
        rd_a(3, v); check("R8 R7 store then load", v, 8'h77);
        // Write-back from ALU with same addressing
        @(negedge clk);
        srca_sel = 0; dst_sel = 3; alu_fn = 5'b00000; wb_from_mem = 0; reg_we = 1;
        @(negedge clk);
        reg_we = 0;
        rd_a(3, v); check("R9 ALU path selected", v, 8'h20);
        // No store with mem_we low
        ld(1, 8'h99);
        @(negedge clk);
        srca_sel = 0; srcb_sel = 1; mem_we = 0;
        @(negedge clk);
        load(0, 2);
        rd_a(2, v); check("R8 no store with mem_we=0", v, 8'h77);
        // All-ones address distinct from zero
        ld(0, 8'hFF); ld(1, 8'h3C); store(0, 1);
        ld(0, 8'h00); ld(1, 8'hA5); store(0, 1);
        ld(0, 8'hFF); load(0, 2);
        rd_a(2, v); check("R10 top address", v, 8'h3C);
        ld(0, 8'h00); load(0, 2);
        rd_a(2, v); check("R10 address zero", v, 8'hA5);
        // Load into the address register itself
        ld(0, 8'h20); load(0, 0);
        rd_a(0, v); check("R9 load into address reg", v, 8'h77);
    endtask

    task automatic t_reset_again();
        logic [7:0] v;
        ld(0, 8'h5A); ld(3, 8'hA5);
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        for (int r = 0; r < 4; r++) begin
            rd_a(2'(r), v);
            check("R1 reset clears", v, 0);
        end
        ld(0, 8'h20); load(0, 1);
        rd_a(1, v); check("R1 RAM kept over reset", v, 8'h77);
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        t_initial_reset();
        t_regs();
        t_alu();
        t_mem();
        t_reset_again();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule